// File: doc/BRIEF.md
# Protection Lookaside Range Checker

This block checks each memory access against a table of protection descriptors before the access goes ahead. There are two tables, one for instruction fetches and one for data accesses, and the instruction flag of the access selects between them. Each descriptor holds a base address and a control word. The control word carries a valid flag, a page-size field and permission and cache-attribute bits. The result is either one exception class (miss, protection violation, multiple hit or misaligned) or a one-cycle hardware-error pulse. Fixed rules for the system register space and the top-byte 0xFF on-chip space apply on top of the table.

The check is combinational from the access inputs to the result outputs. When an access faults, the fault-status and fault-address registers of the selected side are loaded on the next rising clock edge. A data-side fault also records the current program counter on the instruction side. A simple write port loads descriptors and the two memory-control words. A combinational read port returns any register. Register select codes are: 0 base, 1 control word, 2 memory control, 3 fault status, 4 fault address.

A cache-line maintenance check first rounds the address down to the line size. It then reports every fault class except protection violation.

Top module: `prot_range_check`

## Requirements
- R1: A descriptor matches when control bit 0 (valid) is set and base <= address < base + page. The page is set by control bits 17:16: 0 = 1 KB, 1 = 4 KB, 2 = 1 MB, 3 = 4 MB. With the table enabled, an access that matches nothing and falls under no fixed rule reports class 0 (miss).
- R2: On a matching descriptor, three accesses report class 1 (protection): a user read without user-read (bit 2), a user write without user-write (bit 3), and a supervisor write without supervisor-write (bit 4). A supervisor read never faults on permissions.
- R3: A write that hits a descriptor with cacheable (bit 12) set, write-through (bit 14) clear and dirty (bit 7) clear reports class 1.
- R4: An access whose address has any nonzero bit below its size (1 << accSize bytes) reports class 3 (misaligned). Classes are encoded 0 miss, 1 protection, 2 multiple hit, 3 misaligned.
- R5: Two or more matching descriptors report class 2. Priority is multiple hit, then misaligned, then descriptor permission faults, then the fixed region rules.
- R6: When bit 1 of the selected side's memory-control word is clear, the table is skipped. The access counts as a single hit, and only alignment and the fixed rules apply.
- R7: At or above the system base 0xFFC00000, an instruction fetch is class 0. A data access there is class 1 in user mode or from the secondary address generator. A supervisor data access there from the primary generator is allowed.
- R8: Below the system base with top byte 0xFF, instruction fetches are allowed only in 0xFFA00000–0xFFAFFFFF; elsewhere they are class 1. A data access into that 1 MB region gives a hwErr pulse and no exception. Any other data access there is allowed.
- R9: On a fault, the side's status word loads miss at bit 19, secondary generator at bit 18, supervisor at bit 17, write at bit 16 and the bitmap of matching descriptors in bits 15:0. Its fault address loads the checked address. Without a fault, both registers hold.
- R10: On a data-side fault, the instruction fault address loads curPc and the instruction status loads only the supervisor bit 17.
- R11: After reset, both memory-control words read 0x00000001 and all fault registers read 0. Port writes to fault status or fault address are ignored.
- R12: A cache-line check (accCacheOp) rounds the address down to LINE_BYTES (default 32) and skips the size check. A resulting class 1 is not reported, but classes 0 and 2 are.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| cfgWe | input | 1 | Register write strobe |
| cfgInst | input | 1 | Write side: 1 instruction, 0 data |
| cfgSel | input | 3 | Write register select |
| cfgIdx | input | 4 | Descriptor index for write |
| cfgWdata | input | 32 | Write data |
| rdInst | input | 1 | Read side |
| rdSel | input | 3 | Read register select |
| rdIdx | input | 4 | Descriptor index for read |
| rdData | output | 32 | Read data |
| accValid | input | 1 | An access is presented |
| accAddr | input | 32 | Access address |
| accSize | input | 2 | Access size, log2 bytes |
| accWrite | input | 1 | Write access |
| accInst | input | 1 | Instruction fetch (selects table) |
| accSupv | input | 1 | Supervisor mode |
| accDag1 | input | 1 | Secondary address generator |
| accCacheOp | input | 1 | Cache-line maintenance check |
| curPc | input | 32 | Current program counter |
| excValid | output | 1 | An exception is reported |
| excClass | output | 2 | Exception class |
| hwErr | output | 1 | Hardware-error pulse |

## Verification
The assertions assume that configuration writes and accesses never change between clock edges. They also assume that accCacheOp is only raised together with accValid and that accSize never exceeds 3. The bench changes every input at the falling edge and raises accValid for one cycle per access. Descriptors are loaded only while no access is presented. Each access is held through exactly one rising edge, so every fault register update can be attributed to a single access.

// File: rtl/prot_pkg.sv
package prot_pkg;
  localparam int WORD_W = 32;

  typedef enum logic [1:0] {
    CLS_MISS  = 2'd0,
    CLS_PROT  = 2'd1,
    CLS_MULTI = 2'd2,
    CLS_MISAL = 2'd3
  } excCls_e;

  typedef enum logic [2:0] {
    SEL_BASE   = 3'd0,
    SEL_CTRL   = 3'd1,
    SEL_MEMCTL = 3'd2,
    SEL_FSTAT  = 3'd3,
    SEL_FADDR  = 3'd4
  } regSel_e;

  typedef enum logic [2:0] {
    IMP_NONE, IMP_OK, IMP_MISS, IMP_PROT, IMP_HWERR
  } implicit_e;

  // strobes from control to datapath
  typedef struct packed {
    logic logD;
    logic logI;
    logic missBit;
  } logStrobe_t;

  // summary of the table lookup, datapath to control
  typedef struct packed {
    logic        enabled;
    logic        multi;
    logic        single;
    logic        permFault;
    logic [15:0] hitMap;
  } matchSum_t;
endpackage

// File: rtl/prot_store.sv
module prot_store
  import prot_pkg::*;
#(
  parameter int NUM_DESC  = 16,
  parameter int VALID_BIT = 0,
  parameter int URD_BIT   = 2,
  parameter int UWR_BIT   = 3,
  parameter int SWR_BIT   = 4,
  parameter int DIRTY_BIT = 7,
  parameter int CHBL_BIT  = 12,
  parameter int WT_BIT    = 14,
  parameter int EN_BIT    = 1
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              cfgWe,
  input  logic              cfgInst,
  input  logic [2:0]        cfgSel,
  input  logic [3:0]        cfgIdx,
  input  logic [WORD_W-1:0] cfgWdata,
  input  logic              rdInst,
  input  logic [2:0]        rdSel,
  input  logic [3:0]        rdIdx,
  output logic [WORD_W-1:0] rdData,
  input  logic [WORD_W-1:0] chkAddr,
  input  logic              accInst,
  input  logic              accWrite,
  input  logic              accSupv,
  input  logic              accDag1,
  input  logic [WORD_W-1:0] curPc,
  input  logStrobe_t        strobe,
  output matchSum_t         sum
);
  localparam int CNT_W = $clog2(NUM_DESC + 1);

  logic [WORD_W-1:0] baseR [2][NUM_DESC];
  logic [WORD_W-1:0] ctrlR [2][NUM_DESC];
  logic [WORD_W-1:0] memCtl [2];
  logic [WORD_W-1:0] fStat [2];
  logic [WORD_W-1:0] fAddr [2];

  logic [NUM_DESC-1:0] hitVec, permVec;
  logic [CNT_W-1:0]    hitCnt;
  logic                side;

  assign side = accInst;

  // descriptor and control storage
  always_ff @(posedge clk) begin
    if (!rstN) begin
      for (int s = 0; s < 2; s++) begin
        memCtl[s] <= 32'h1;
        for (int i = 0; i < NUM_DESC; i++) begin
          baseR[s][i] <= '0;
          ctrlR[s][i] <= '0;
        end
      end
    end else if (cfgWe) begin
      case (cfgSel)
        SEL_BASE:   baseR[cfgInst][cfgIdx] <= cfgWdata;
        SEL_CTRL:   ctrlR[cfgInst][cfgIdx] <= cfgWdata;
        SEL_MEMCTL: memCtl[cfgInst] <= cfgWdata;
        default: ;  // fault registers are not writable
      endcase
    end
  end

  // fault logging
  always_ff @(posedge clk) begin
    if (!rstN) begin
      fStat[0] <= '0; fStat[1] <= '0;
      fAddr[0] <= '0; fAddr[1] <= '0;
    end else begin
      if (strobe.logD) begin
        fStat[0] <= {12'd0, strobe.missBit, accDag1, accSupv, accWrite, sum.hitMap};
        fAddr[0] <= chkAddr;
        fStat[1] <= {14'd0, accSupv, 17'd0};
        fAddr[1] <= curPc;
      end else if (strobe.logI) begin
        fStat[1] <= {12'd0, strobe.missBit, accDag1, accSupv, accWrite, sum.hitMap};
        fAddr[1] <= chkAddr;
      end
    end
  end

  // per-descriptor range and permission check
  for (genvar g = 0; g < NUM_DESC; g++) begin : g_desc
    logic [WORD_W-1:0] cw;
    logic [WORD_W:0]   pageEnd;
    logic [22:0]       pageBytes;
    assign cw = ctrlR[side][g];
    always_comb begin
      case (cw[17:16])
        2'd0:    pageBytes = 23'd1 << 10;
        2'd1:    pageBytes = 23'd1 << 12;
        2'd2:    pageBytes = 23'd1 << 20;
        default: pageBytes = 23'd1 << 22;
      endcase
      pageEnd = {1'b0, baseR[side][g]} + {10'd0, pageBytes};
      hitVec[g] = cw[VALID_BIT] && (chkAddr >= baseR[side][g])
                  && ({1'b0, chkAddr} < pageEnd);
      if (accWrite)
        permVec[g] = (!accSupv && !cw[UWR_BIT]) || (accSupv && !cw[SWR_BIT])
                     || (cw[CHBL_BIT] && !cw[WT_BIT] && !cw[DIRTY_BIT]);
      else
        permVec[g] = !accSupv && !cw[URD_BIT];
    end
  end

  always_comb begin
    hitCnt = '0;
    for (int i = 0; i < NUM_DESC; i++) hitCnt = hitCnt + CNT_W'(hitVec[i]);
    sum.enabled   = memCtl[side][EN_BIT];
    sum.multi     = sum.enabled && (hitCnt >= CNT_W'(2));
    sum.single    = !sum.enabled || (hitCnt == CNT_W'(1));
    sum.permFault = sum.enabled && |(hitVec & permVec);
    sum.hitMap    = '0;
    if (sum.enabled) sum.hitMap[NUM_DESC-1:0] = hitVec;
  end

  always_comb begin
    case (rdSel)
      SEL_BASE:   rdData = baseR[rdInst][rdIdx];
      SEL_CTRL:   rdData = ctrlR[rdInst][rdIdx];
      SEL_MEMCTL: rdData = memCtl[rdInst];
      SEL_FSTAT:  rdData = fStat[rdInst];
      SEL_FADDR:  rdData = fAddr[rdInst];
      default:    rdData = '0;
    endcase
  end

  // R9: without a logging strobe the data status holds
  a_r9_status_hold: assert property (@(posedge clk) disable iff (!rstN)
    !strobe.logD |=> $stable(fStat[0]));
  // R10: data fault records the program counter on the instruction side
  a_r10_pc_capture: assert property (@(posedge clk) disable iff (!rstN)
    strobe.logD |=> fAddr[1] == $past(curPc));
  // R11: memory control never changes without a port write
  a_r11_memctl_hold: assert property (@(posedge clk) disable iff (!rstN)
    !cfgWe |=> $stable(memCtl[0]) && $stable(memCtl[1]));
endmodule

// File: rtl/prot_decide.sv
module prot_decide
  import prot_pkg::*;
#(
  parameter int                LINE_BYTES = 32,
  parameter logic [WORD_W-1:0] SYS_BASE   = 32'hFFC0_0000
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              accValid,
  input  logic [WORD_W-1:0] accAddr,
  input  logic [1:0]        accSize,
  input  logic              accInst,
  input  logic              accSupv,
  input  logic              accDag1,
  input  logic              accCacheOp,
  input  matchSum_t         sum,
  output logic [WORD_W-1:0] chkAddr,
  output logic              excValid,
  output logic [1:0]        excClass,
  output logic              hwErr,
  output logStrobe_t        strobe
);
  localparam logic [WORD_W-1:0] LINE_MASK = WORD_W'(LINE_BYTES - 1);

  logic [2:0] sizeMask;
  logic       misal, fault, topFF, instRegion;
  implicit_e  imp;
  excCls_e    cls;

  assign chkAddr = accCacheOp ? (accAddr & ~LINE_MASK) : accAddr;

  always_comb begin
    sizeMask   = accCacheOp ? 3'd0 : 3'((4'd1 << accSize) - 4'd1);
    misal      = |(chkAddr[2:0] & sizeMask);
    topFF      = chkAddr[31:24] == 8'hFF;
    instRegion = chkAddr[31:20] == 12'hFFA;
    if (chkAddr >= SYS_BASE)
      imp = accInst ? IMP_MISS : ((!accSupv || accDag1) ? IMP_PROT : IMP_OK);
    else if (topFF && accInst)
      imp = instRegion ? IMP_OK : IMP_PROT;
    else if (topFF)
      imp = instRegion ? IMP_HWERR : IMP_OK;
    else
      imp = IMP_NONE;
  end

  always_comb begin
    fault = 1'b1;
    hwErr = 1'b0;
    cls   = CLS_MISS;
    if (sum.multi)          cls = CLS_MULTI;
    else if (misal)         cls = CLS_MISAL;
    else if (sum.permFault) cls = CLS_PROT;
    else begin
      case (imp)
        IMP_OK:    fault = 1'b0;
        IMP_PROT:  cls = CLS_PROT;
        IMP_MISS:  cls = CLS_MISS;
        IMP_HWERR: begin fault = 1'b0; hwErr = accValid; end
        default:   fault = !sum.single;
      endcase
    end
    fault = fault && accValid;
  end

  assign excClass       = cls;
  assign excValid       = fault && !(accCacheOp && cls == CLS_PROT);
  assign strobe.logD    = fault && !accInst;
  assign strobe.logI    = fault && accInst;
  assign strobe.missBit = cls == CLS_MISS;

  // R5: a multiple match from the table always wins
  a_r5_multi_wins: assert property (@(posedge clk) disable iff (!rstN)
    accValid && sum.multi |-> excValid && excClass == CLS_MULTI);
  // R12: cache-line checks never report a protection violation
  a_r12_cache_no_prot: assert property (@(posedge clk) disable iff (!rstN)
    accValid && accCacheOp |-> !(excValid && excClass == CLS_PROT));
  // R8: hardware error and exception are exclusive
  a_r8_hw_exclusive: assert property (@(posedge clk) disable iff (!rstN)
    !(hwErr && excValid));
  // R6: with the table off no multiple hit is possible
  a_r6_off_no_multi: assert property (@(posedge clk) disable iff (!rstN)
    accValid && !sum.enabled |-> !(excValid && excClass == CLS_MULTI));
endmodule

// File: rtl/prot_range_check.sv
module prot_range_check
  import prot_pkg::*;
#(
  parameter int NUM_DESC   = 16,
  parameter int LINE_BYTES = 32
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        cfgWe,
  input  logic        cfgInst,
  input  logic [2:0]  cfgSel,
  input  logic [3:0]  cfgIdx,
  input  logic [31:0] cfgWdata,
  input  logic        rdInst,
  input  logic [2:0]  rdSel,
  input  logic [3:0]  rdIdx,
  output logic [31:0] rdData,
  input  logic        accValid,
  input  logic [31:0] accAddr,
  input  logic [1:0]  accSize,
  input  logic        accWrite,
  input  logic        accInst,
  input  logic        accSupv,
  input  logic        accDag1,
  input  logic        accCacheOp,
  input  logic [31:0] curPc,
  output logic        excValid,
  output logic [1:0]  excClass,
  output logic        hwErr
);
  matchSum_t         sum;
  logStrobe_t        strobe;
  logic [WORD_W-1:0] chkAddr;

  prot_store #(.NUM_DESC(NUM_DESC)) uStore (
    .clk(clk), .rstN(rstN), .cfgWe(cfgWe), .cfgInst(cfgInst), .cfgSel(cfgSel),
    .cfgIdx(cfgIdx), .cfgWdata(cfgWdata), .rdInst(rdInst), .rdSel(rdSel),
    .rdIdx(rdIdx), .rdData(rdData), .chkAddr(chkAddr), .accInst(accInst),
    .accWrite(accWrite), .accSupv(accSupv), .accDag1(accDag1), .curPc(curPc),
    .strobe(strobe), .sum(sum));

  prot_decide #(.LINE_BYTES(LINE_BYTES)) uDecide (
    .clk(clk), .rstN(rstN), .accValid(accValid), .accAddr(accAddr),
    .accSize(accSize), .accInst(accInst), .accSupv(accSupv), .accDag1(accDag1),
    .accCacheOp(accCacheOp), .sum(sum), .chkAddr(chkAddr), .excValid(excValid),
    .excClass(excClass), .hwErr(hwErr), .strobe(strobe));
endmodule

// File: tb/prot_range_check_test.sv
module prot_range_check_test;
  logic clk = 1'b0, rstN = 1'b0;
  logic cfgWe = 0, cfgInst = 0, rdInst = 0;
  logic [2:0] cfgSel = 0, rdSel = 0;
  logic [3:0] cfgIdx = 0, rdIdx = 0;
  logic [31:0] cfgWdata = 0, rdData, accAddr = 0, curPc = 0;
  logic accValid = 0, accWrite = 0, accInst = 0, accSupv = 0, accDag1 = 0, accCacheOp = 0;
  logic [1:0] accSize = 0, excClass;
  logic excValid, hwErr;
  int total = 0, bad = 0;
  bit finished = 0;

  always #5 clk = ~clk;

  prot_range_check uut (.*);

  typedef struct packed {
    logic [3:0] rq; logic [31:0] addr; logic [1:0] sz;
    logic wr, ins, sv, d1, co, eExc; logic [1:0] eCls; logic eHw;
  } vec_t;

  localparam int NV = 29;
  localparam vec_t VECS [NV] = '{
    '{4'd1,  32'h0000_1004, 2'd2, 1'b0,1'b0,1'b0,1'b0,1'b0, 1'b0,2'd0,1'b0}, // R1 hit ok
    '{4'd1,  32'h0000_1FFC, 2'd2, 1'b0,1'b0,1'b0,1'b0,1'b0, 1'b0,2'd0,1'b0}, // R1 last word
    '{4'd1,  32'h0000_2400, 2'd2, 1'b0,1'b0,1'b1,1'b0,1'b0, 1'b1,2'd0,1'b0}, // R1 past 1KB
    '{4'd1,  32'h0000_23FC, 2'd2, 1'b0,1'b0,1'b1,1'b0,1'b0, 1'b0,2'd0,1'b0}, // R1 inside 1KB
    '{4'd4,  32'h0000_1006, 2'd2, 1'b0,1'b0,1'b0,1'b0,1'b0, 1'b1,2'd3,1'b0}, // R4
    '{4'd2,  32'h0000_2010, 2'd2, 1'b0,1'b0,1'b0,1'b0,1'b0, 1'b1,2'd1,1'b0}, // R2 user rd
    '{4'd2,  32'h0000_2010, 2'd2, 1'b0,1'b0,1'b1,1'b0,1'b0, 1'b0,2'd0,1'b0}, // R2 supv rd
    '{4'd2,  32'h0000_2010, 2'd2, 1'b1,1'b0,1'b0,1'b0,1'b0, 1'b1,2'd1,1'b0}, // R2 user wr
    '{4'd2,  32'h0000_2010, 2'd2, 1'b1,1'b0,1'b1,1'b0,1'b0, 1'b0,2'd0,1'b0}, // R2 supv wr
    '{4'd1,  32'h0000_3000, 2'd2, 1'b0,1'b0,1'b0,1'b0,1'b0, 1'b1,2'd0,1'b0}, // R1 miss
    '{4'd5,  32'h0010_0800, 2'd2, 1'b0,1'b0,1'b0,1'b0,1'b0, 1'b1,2'd2,1'b0}, // R5 multi
    '{4'd5,  32'h0010_0801, 2'd2, 1'b0,1'b0,1'b0,1'b0,1'b0, 1'b1,2'd2,1'b0}, // R5 multi over misal
    '{4'd5,  32'h0000_2011, 2'd1, 1'b0,1'b0,1'b0,1'b0,1'b0, 1'b1,2'd3,1'b0}, // R5 misal over prot
    '{4'd3,  32'h0018_0000, 2'd2, 1'b1,1'b0,1'b1,1'b0,1'b0, 1'b1,2'd1,1'b0}, // R3 clean wr
    '{4'd3,  32'h0018_0000, 2'd2, 1'b0,1'b0,1'b1,1'b0,1'b0, 1'b0,2'd0,1'b0}, // R3 read ok
    '{4'd7,  32'hFFC0_0100, 2'd2, 1'b0,1'b0,1'b1,1'b0,1'b0, 1'b0,2'd0,1'b0}, // R7 supv ok
    '{4'd7,  32'hFFC0_0100, 2'd2, 1'b0,1'b0,1'b0,1'b0,1'b0, 1'b1,2'd1,1'b0}, // R7 user
    '{4'd7,  32'hFFC0_0100, 2'd2, 1'b0,1'b0,1'b1,1'b1,1'b0, 1'b1,2'd1,1'b0}, // R7 dag1
    '{4'd7,  32'hFFC0_0100, 2'd2, 1'b0,1'b1,1'b1,1'b0,1'b0, 1'b1,2'd0,1'b0}, // R7 fetch
    '{4'd8,  32'hFFA0_0010, 2'd2, 1'b0,1'b0,1'b1,1'b0,1'b0, 1'b0,2'd0,1'b1}, // R8 hwErr
    '{4'd8,  32'hFF80_0000, 2'd2, 1'b0,1'b0,1'b1,1'b0,1'b0, 1'b0,2'd0,1'b0}, // R8 data ok
    '{4'd8,  32'hFFA0_0010, 2'd2, 1'b0,1'b1,1'b1,1'b0,1'b0, 1'b0,2'd0,1'b0}, // R8 fetch ok
    '{4'd8,  32'hFF80_0000, 2'd2, 1'b0,1'b1,1'b1,1'b0,1'b0, 1'b1,2'd1,1'b0}, // R8 fetch prot
    '{4'd1,  32'h0000_4100, 2'd1, 1'b0,1'b1,1'b0,1'b0,1'b0, 1'b0,2'd0,1'b0}, // R1 inst 4MB
    '{4'd1,  32'h0040_3FFC, 2'd2, 1'b0,1'b1,1'b0,1'b0,1'b0, 1'b0,2'd0,1'b0}, // R1 inst end
    '{4'd1,  32'h0040_4000, 2'd2, 1'b0,1'b1,1'b0,1'b0,1'b0, 1'b1,2'd0,1'b0}, // R1 inst past
    '{4'd12, 32'h0000_2013, 2'd0, 1'b0,1'b0,1'b0,1'b0,1'b1, 1'b0,2'd0,1'b0}, // R12 prot hidden
    '{4'd12, 32'h0000_3005, 2'd0, 1'b0,1'b0,1'b0,1'b0,1'b1, 1'b1,2'd0,1'b0}, // R12 miss shown
    '{4'd12, 32'h0010_0810, 2'd0, 1'b0,1'b0,1'b0,1'b0,1'b1, 1'b1,2'd2,1'b0}  // R12 multi shown
  };

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic cfgWrite(input logic ins, input logic [2:0] sel, input logic [3:0] idx,
                          input logic [31:0] d);
    @(negedge clk);
    cfgWe = 1; cfgInst = ins; cfgSel = sel; cfgIdx = idx; cfgWdata = d;
    @(negedge clk);
    cfgWe = 0;
  endtask

  task automatic readReg(input logic ins, input logic [2:0] sel, input logic [3:0] idx,
                         output logic [31:0] d);
    rdInst = ins; rdSel = sel; rdIdx = idx;
    #1 d = rdData;
  endtask

  // present one access for one rising edge; outputs are sampled before that edge
  task automatic access(input vec_t v, input logic [31:0] pc,
                        output logic e, output logic [1:0] c, output logic h);
    @(negedge clk);
    accValid = 1; accAddr = v.addr; accSize = v.sz; accWrite = v.wr; accInst = v.ins;
    accSupv = v.sv; accDag1 = v.d1; accCacheOp = v.co; curPc = pc;
    #2 e = excValid; c = excClass; h = hwErr;
    @(posedge clk);
    #1 accValid = 0; accCacheOp = 0;
  endtask

  initial begin
    #2_000_000;
    if (!finished) begin
      total++; bad++;
      $display("FAIL watchdog actual=running expected=done");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    logic [31:0] d;
    logic e, h;
    logic [1:0] c;
    repeat (3) @(negedge clk);
    rstN = 1;
    // R11 reset state
    readReg(0, 3'd2, 0, d); check("R11 data memctl reset", d, 32'h1);
    readReg(1, 3'd2, 0, d); check("R11 inst memctl reset", d, 32'h1);
    readReg(0, 3'd3, 0, d); check("R11 data status reset", d, 32'h0);
    readReg(1, 3'd4, 0, d); check("R11 inst addr reset", d, 32'h0);
    cfgWrite(0, 3'd3, 0, 32'hFFFF_FFFF);
    cfgWrite(1, 3'd4, 0, 32'h1234_5678);
    readReg(0, 3'd3, 0, d); check("R11 status write ignored", d, 32'h0);
    readReg(1, 3'd4, 0, d); check("R11 addr write ignored", d, 32'h0);

    // descriptors: valid=0 urd=2 uwr=3 swr=4 dirty=7 chbl=12 wt=14, page 17:16
    cfgWrite(0, 3'd0, 0, 32'h0000_1000); cfgWrite(0, 3'd1, 0, 32'h0001_001D);
    cfgWrite(0, 3'd0, 1, 32'h0000_2000); cfgWrite(0, 3'd1, 1, 32'h0000_0011);
    cfgWrite(0, 3'd0, 2, 32'h0010_0000); cfgWrite(0, 3'd1, 2, 32'h0002_101D);
    cfgWrite(0, 3'd0, 3, 32'h0010_0000); cfgWrite(0, 3'd1, 3, 32'h0001_0005);
    cfgWrite(1, 3'd0, 0, 32'h0000_4000); cfgWrite(1, 3'd1, 0, 32'h0003_0005);
    cfgWrite(0, 3'd2, 0, 32'h3);
    cfgWrite(1, 3'd2, 0, 32'h3);
    readReg(0, 3'd1, 2, d); check("R1 control readback", d, 32'h0002_101D);

    for (int i = 0; i < NV; i++) begin
      access(VECS[i], 32'h100 + i, e, c, h);
      total++;
      if (e !== VECS[i].eExc || (VECS[i].eExc && c !== VECS[i].eCls) || h !== VECS[i].eHw) begin
        bad++;
        $display("FAIL R%0d vector %0d actual=exc%b cls%0d hw%b expected=exc%b cls%0d hw%b",
                 VECS[i].rq, i, e, c, h, VECS[i].eExc, VECS[i].eCls, VECS[i].eHw);
      end
    end

    // R9 / R10 fault register contents
    access('{4'd9, 32'h0000_3000, 2'd2, 1'b0,1'b0,1'b0,1'b0,1'b0, 1'b1,2'd0,1'b0},
           32'h0000_1234, e, c, h);
    readReg(0, 3'd3, 0, d); check("R9 miss status", d, 32'h0008_0000);
    readReg(0, 3'd4, 0, d); check("R9 fault addr", d, 32'h0000_3000);
    readReg(1, 3'd4, 0, d); check("R10 pc captured", d, 32'h0000_1234);
    readReg(1, 3'd3, 0, d); check("R10 inst status user", d, 32'h0);
    access('{4'd9, 32'h0010_0800, 2'd2, 1'b1,1'b0,1'b1,1'b1,1'b0, 1'b1,2'd2,1'b0},
           32'h0000_5678, e, c, h);
    check("R5 multi write dag1", {30'd0, c}, 32'd2);
    readReg(0, 3'd3, 0, d); check("R9 multi status map", d, 32'h0007_000C);
    readReg(1, 3'd3, 0, d); check("R10 inst status supv", d, 32'h0002_0000);
    access('{4'd9, 32'h0000_1004, 2'd2, 1'b0,1'b0,1'b0,1'b0,1'b0, 1'b0,2'd0,1'b0},
           32'h0000_9999, e, c, h);
    readReg(0, 3'd3, 0, d); check("R9 status holds on success", d, 32'h0007_000C);
    readReg(1, 3'd4, 0, d); check("R10 pc holds on success", d, 32'h0000_5678);
    access('{4'd9, 32'h0050_0000, 2'd2, 1'b0,1'b1,1'b1,1'b0,1'b0, 1'b1,2'd0,1'b0},
           32'h0, e, c, h);
    readReg(1, 3'd3, 0, d); check("R9 inst miss status", d, 32'h000A_0000);
    readReg(1, 3'd4, 0, d); check("R9 inst fault addr", d, 32'h0050_0000);

    // R6 table disabled on the data side
    cfgWrite(0, 3'd2, 0, 32'h1);
    access('{4'd6, 32'h0000_3000, 2'd2, 1'b0,1'b0,1'b0,1'b0,1'b0, 1'b0,2'd0,1'b0},
           32'h0, e, c, h);
    check("R6 off no miss", {31'd0, e}, 32'd0);
    access('{4'd6, 32'h0000_2010, 2'd2, 1'b0,1'b0,1'b0,1'b0,1'b0, 1'b0,2'd0,1'b0},
           32'h0, e, c, h);
    check("R6 off no permission", {31'd0, e}, 32'd0);
    access('{4'd6, 32'hFFC0_0100, 2'd2, 1'b0,1'b0,1'b0,1'b0,1'b0, 1'b1,2'd1,1'b0},
           32'h0, e, c, h);
    check("R6 off implicit prot", {30'd0, c, 1'b0, e} , {30'd1, 1'b0, 1'b1});
    access('{4'd6, 32'h0000_1002, 2'd2, 1'b0,1'b0,1'b0,1'b0,1'b0, 1'b1,2'd3,1'b0},
           32'h0, e, c, h);
    check("R6 off misaligned", {30'd0, c}, 32'd3);

    finished = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule